// File: doc/BRIEF.md
# Register-Offset Load/Store Decoder and Address Generator

This block takes one 32-bit load/store instruction of the register-plus-register offset form and decodes it. It sorts the instruction into one of seven classes: integer store, zero-extending load, sign-extending load, vector store, vector load, prefetch, or unallocated. For an allocated instruction it reports the transfer size, the signedness, the destination register width, whether a register is written, and the three register indices.

In the same cycle it computes the effective address. The caller supplies the general register value for the base index, the current stack pointer and the value for the offset index. The block picks the stack pointer when the base index is 31 and forces the offset to zero when the offset index is 31. It then extends the offset, optionally scales it by the access size, and adds it to the base. When the stack pointer is the base and it is not 16-byte aligned, the block raises a fault flag.

All results are registered and appear one clock after the input strobe. Register reads, memory access and tag checks are left to the surrounding pipeline.

Top module: `ldst_roff_decoder`

## Requirements
- R1: The instruction is unallocated (out_kind 6) when any fixed field differs from its required value: bits[29:27] must be 111, bits[25:24] must be 00, bit[21] must be 1 and bits[11:10] must be 10. It is also unallocated when opt bit[14] is 0.
- R2: For integer instructions (bit[26]=0), out_size equals size bits[31:30], giving log2 of the byte count. opc bits[23:22] select the class: 00 is a store (kind 0), 01 is a zero-extending load (kind 1), and 10 or 11 is a sign-extending load (kind 2, out_signed=1).
- R3: Integer opc 11 with size above 01 is unallocated. Integer size 11 with opc 10 is a prefetch: kind 5, out_reg_write=0, out_size 3.
- R4: For vector instructions (bit[26]=1), out_size is {opc[1], size}. A value above 4 is unallocated. Otherwise opc[0]=1 gives a vector load (kind 4) and opc[0]=0 gives a vector store (kind 3).
- R5: out_dst64 is 1 for integer opc 10 loads and for integer size-11 stores and loads. It is 0 for opc 11 loads, for opc 01 or 00 with size below 11, and for every vector instruction. out_reg_write is 1 exactly for the load kinds 1, 2 and 4.
- R6: The offset is extended according to opt bits[15:13]:
  - 010: the low 32 bits, zero-extended.
  - 110: the low 32 bits, sign-extended.
  - 011 or 111: all 64 bits.
- R7: When S bit[12] is 1, the extended offset is shifted left by out_size before the add. When S is 0 it is not shifted. The address wraps modulo 2^64.
- R8: A base index bits[9:5] of 31 selects in_sp as the base. An offset index bits[20:16] of 31 reads as zero.
- R9: out_sp_fault is 1 when the instruction is allocated, the base index is 31 and in_sp[3:0] is nonzero. It is 0 otherwise.
- R10: Every output is registered one cycle after in_valid, and out_valid follows in_valid by one cycle. A cycle with in_valid low produces out_kind 7 with all other outputs zero. An unallocated instruction produces zero on every output except out_valid, out_unalloc and out_kind.
- R11: During reset, out_valid is 0, out_kind is 7 and all other outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction strobe |
| in_insn | input | 32 | Instruction word |
| in_base | input | 64 | General register value for the base index |
| in_sp | input | 64 | Current stack pointer |
| in_offset | input | 64 | General register value for the offset index |
| out_valid | output | 1 | Result valid |
| out_unalloc | output | 1 | Unallocated encoding |
| out_kind | output | 3 | Class code (0..7) |
| out_size | output | 3 | log2 of access bytes |
| out_signed | output | 1 | Sign-extending load |
| out_dst64 | output | 1 | Destination written at 64 bits |
| out_reg_write | output | 1 | Destination register is written |
| out_rt | output | 5 | Transfer register index |
| out_rn | output | 5 | Base register index |
| out_rm | output | 5 | Offset register index |
| out_addr | output | 64 | Effective address |
| out_sp_fault | output | 1 | Stack pointer misaligned |

## Verification
The bench targets the boundaries of the decode.

- Vector size 4 must stay legal while 5 through 7 are rejected. A comparator that is off by one either rejects 128-bit accesses or admits size 5.
- The opc 11 sign load must stay legal at sizes 00 and 01 and be rejected at 10 and 11. That case must also report a 32-bit destination, or the upper half of the register would be corrupted.
- A prefetch must never write a register.

The bench also drives offsets with bit 31 set under each extend mode and each scale. A swapped sign or zero extend, or a scale taken from the raw size field instead of the vector size, shows up as a wrong address. Stack-pointer cases cover misaligned pointers and base index 31 together with offset index 31. Unallocated cases carry nonzero operands, so any leak onto the outputs is visible.

// File: rtl/ldst_pkg.sv
// Shared types for the register-offset load/store decoder.
// Assumes 32-bit instruction words and 5-bit register indices.
package ldst_pkg;
    localparam int INSN_W = 32;
    localparam int IDX_W  = 5;

    typedef enum logic [2:0] {
        K_STORE    = 3'd0,
        K_LOAD_U   = 3'd1,
        K_LOAD_S   = 3'd2,
        K_VSTORE   = 3'd3,
        K_VLOAD    = 3'd4,
        K_PREFETCH = 3'd5,
        K_UNALLOC  = 3'd6,
        K_IDLE     = 3'd7
    } kind_t;

    typedef struct packed {
        kind_t      kind;
        logic [2:0] size;
        logic       signd;
        logic       dst64;
        logic       wr;
    } dec_t;
endpackage

// File: rtl/ldst_field_decode.sv
// Classifies an instruction word: kind, size, signedness, destination width
// and register write. Purely combinational. Assumes the word is already
// known to belong to the load/store group; the fixed bits are still checked.
module ldst_field_decode
    import ldst_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    logic [1:0] sz;
    logic [1:0] opc;
    logic       vec;
    logic       fixed_ok;
    logic [2:0] vsz;

    assign sz       = insn[31:30];
    assign opc      = insn[23:22];
    assign vec      = insn[26];
    assign fixed_ok = (insn[29:27] == 3'b111) && (insn[25:24] == 2'b00) &&
                      insn[21] && (insn[11:10] == 2'b10) && insn[14];
    assign vsz      = {opc[1], sz};

    // Purpose: map the opc/size/vector fields to a class and its attributes.
    always_comb begin
        dec = '{kind: K_UNALLOC, size: 3'd0, signd: 1'b0, dst64: 1'b0, wr: 1'b0};
        if (fixed_ok) begin
            if (vec) begin
                if (vsz <= 3'd4) begin
                    dec.kind = opc[0] ? K_VLOAD : K_VSTORE;
                    dec.size = vsz;
                    dec.wr   = opc[0];
                end
            end else if (sz == 2'b11 && opc == 2'b10) begin
                dec.kind = K_PREFETCH;
                dec.size = 3'd3;
            end else if (!(opc == 2'b11 && sz[1])) begin
                dec.size = {1'b0, sz};
                case (opc)
                    2'b00: begin
                        dec.kind  = K_STORE;
                        dec.dst64 = (sz == 2'b11);
                    end
                    2'b01: begin
                        dec.kind  = K_LOAD_U;
                        dec.dst64 = (sz == 2'b11);
                        dec.wr    = 1'b1;
                    end
                    2'b10: begin
                        dec.kind  = K_LOAD_S;
                        dec.signd = 1'b1;
                        dec.dst64 = 1'b1;
                        dec.wr    = 1'b1;
                    end
                    default: begin
                        dec.kind  = K_LOAD_S;
                        dec.signd = 1'b1;
                        dec.wr    = 1'b1;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/ldst_addr_gen.sv
// Effective address: selects the base (stack pointer on index 31) and the
// offset (zero on index 31), extends and scales the offset, then adds.
// Also flags a stack-pointer base that breaks the alignment rule.
// Assumes ADDR_W >= 64 is not required; the extend modes use the low half.
module ldst_addr_gen #(
    parameter int ADDR_W     = 64,
    parameter int ALIGN_BITS = 4
) (
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] sp_val,
    input  logic [ADDR_W-1:0] off_val,
    input  logic [4:0]        rn,
    input  logic [4:0]        rm,
    input  logic [2:0]        opt,
    input  logic              scale_en,
    input  logic [2:0]        size,
    output logic [ADDR_W-1:0] addr,
    output logic              sp_misaligned
);
    localparam int HALF_W = ADDR_W / 2;

    logic [ADDR_W-1:0] base_sel;
    logic [ADDR_W-1:0] off_sel;
    logic [ADDR_W-1:0] off_ext;
    logic [2:0]        shamt;

    assign base_sel = (rn == 5'd31) ? sp_val : base_val;
    assign off_sel  = (rm == 5'd31) ? '0 : off_val;
    assign shamt    = scale_en ? size : 3'd0;

    // Purpose: apply the word/doubleword extend chosen by opt.
    always_comb begin
        case (opt)
            3'b010:  off_ext = {{HALF_W{1'b0}}, off_sel[HALF_W-1:0]};
            3'b110:  off_ext = {{HALF_W{off_sel[HALF_W-1]}}, off_sel[HALF_W-1:0]};
            default: off_ext = off_sel;
        endcase
    end

    assign addr = base_sel + (off_ext << shamt);

    generate
        if (ALIGN_BITS > 0) begin : g_align
            assign sp_misaligned = (rn == 5'd31) && (sp_val[ALIGN_BITS-1:0] != '0);
        end else begin : g_noalign
            assign sp_misaligned = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/ldst_roff_decoder.sv
// Top: decodes a register-offset load/store and registers the decode and the
// effective address one cycle after in_valid. Unallocated encodings and idle
// cycles drive zero on all data outputs. Synchronous active-low reset.
module ldst_roff_decoder
    import ldst_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int ALIGN_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_insn,
    input  logic [ADDR_W-1:0] in_base,
    input  logic [ADDR_W-1:0] in_sp,
    input  logic [ADDR_W-1:0] in_offset,
    output logic              out_valid,
    output logic              out_unalloc,
    output logic [2:0]        out_kind,
    output logic [2:0]        out_size,
    output logic              out_signed,
    output logic              out_dst64,
    output logic              out_reg_write,
    output logic [4:0]        out_rt,
    output logic [4:0]        out_rn,
    output logic [4:0]        out_rm,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_sp_fault
);
    dec_t              dec;
    logic [ADDR_W-1:0] addr_c;
    logic              mis_c;
    logic              alloc;

    ldst_field_decode u_dec (
        .insn (in_insn),
        .dec  (dec)
    );

    ldst_addr_gen #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_agen (
        .base_val      (in_base),
        .sp_val        (in_sp),
        .off_val       (in_offset),
        .rn            (in_insn[9:5]),
        .rm            (in_insn[20:16]),
        .opt           (in_insn[15:13]),
        .scale_en      (in_insn[12]),
        .size          (dec.size),
        .addr          (addr_c),
        .sp_misaligned (mis_c)
    );

    assign alloc = (dec.kind != K_UNALLOC);

    // Purpose: register the decode; zero everything on idle or unallocated.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid     <= 1'b0;
            out_unalloc   <= 1'b0;
            out_kind      <= K_IDLE;
            out_size      <= '0;
            out_signed    <= 1'b0;
            out_dst64     <= 1'b0;
            out_reg_write <= 1'b0;
            out_rt        <= '0;
            out_rn        <= '0;
            out_rm        <= '0;
            out_addr      <= '0;
            out_sp_fault  <= 1'b0;
        end else begin
            out_valid     <= 1'b1;
            out_unalloc   <= !alloc;
            out_kind      <= dec.kind;
            out_size      <= alloc ? dec.size : 3'd0;
            out_signed    <= alloc && dec.signd;
            out_dst64     <= alloc && dec.dst64;
            out_reg_write <= alloc && dec.wr;
            out_rt        <= alloc ? in_insn[4:0] : 5'd0;
            out_rn        <= alloc ? in_insn[9:5] : 5'd0;
            out_rm        <= alloc ? in_insn[20:16] : 5'd0;
            out_addr      <= alloc ? addr_c : '0;
            out_sp_fault  <= alloc && mis_c;
        end
    end
endmodule

// File: rtl/ldst_roff_checker.sv
// Protocol and decode invariants for ldst_roff_decoder, bound to the top.
module ldst_roff_checker #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_valid,
    input logic              out_unalloc,
    input logic [2:0]        out_kind,
    input logic [2:0]        out_size,
    input logic              out_signed,
    input logic              out_dst64,
    input logic              out_reg_write,
    input logic [4:0]        out_rn,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_sp_fault
);
    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && out_kind == 3'd7));
    p_unalloc_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_unalloc |-> (out_kind == 3'd6 && out_addr == '0 && !out_reg_write && !out_sp_fault));
    p_prefetch_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 3'd5) |-> (!out_reg_write && out_size == 3'd3));
    p_vec_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_kind == 3'd3 || out_kind == 3'd4)) |-> (out_size <= 3'd4 && !out_dst64));
    p_narrow_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_kind == 3'd2 && !out_dst64) |-> (out_size <= 3'd1 && out_signed));
    p_fault_sp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_sp_fault |-> (out_rn == 5'd31));
endmodule

bind ldst_roff_decoder ldst_roff_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .out_valid     (out_valid),
    .out_unalloc   (out_unalloc),
    .out_kind      (out_kind),
    .out_size      (out_size),
    .out_signed    (out_signed),
    .out_dst64     (out_dst64),
    .out_reg_write (out_reg_write),
    .out_rn        (out_rn),
    .out_addr      (out_addr),
    .out_sp_fault  (out_sp_fault)
);

// File: tb/ldst_roff_decoder_tb_top.sv
module ldst_roff_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_insn = '0;
    logic [63:0] in_base = '0, in_sp = '0, in_offset = '0;
    logic        out_valid, out_unalloc, out_signed, out_dst64, out_reg_write, out_sp_fault;
    logic [2:0]  out_kind, out_size;
    logic [4:0]  out_rt, out_rn, out_rm;
    logic [63:0] out_addr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ldst_roff_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
        .in_base(in_base), .in_sp(in_sp), .in_offset(in_offset),
        .out_valid(out_valid), .out_unalloc(out_unalloc), .out_kind(out_kind),
        .out_size(out_size), .out_signed(out_signed), .out_dst64(out_dst64),
        .out_reg_write(out_reg_write), .out_rt(out_rt), .out_rn(out_rn),
        .out_rm(out_rm), .out_addr(out_addr), .out_sp_fault(out_sp_fault)
    );

    // Expected output packed as {valid,unalloc,kind,size,signed,dst64,wr,rt,rn,rm,fault,addr}
    typedef struct packed {
        logic v, un; logic [2:0] k, sz; logic sg, d64, wr;
        logic [4:0] rt, rn, rm; logic flt; logic [63:0] a;
    } exp_t;

    exp_t  pend[$];
    string ptag[$];

    function automatic logic [31:0] mk(input int sz, input int v, input int opc, input int rm,
                                       input int opt, input int s, input int rn, input int rt);
        return {sz[1:0], 3'b111, v[0], 2'b00, opc[1:0], 1'b1, rm[4:0], opt[2:0], s[0],
                2'b10, rn[4:0], rt[4:0]};
    endfunction

    function automatic exp_t idle_exp();
        exp_t e = '0;
        e.k = 3'd7;
        return e;
    endfunction

    // Behavioural model written from the requirements.
    function automatic exp_t model(input logic [31:0] w, input logic [63:0] b,
                                   input logic [63:0] sp, input logic [63:0] o);
        exp_t e = '0;
        int sz = int'(w[31:30]);
        int opc = int'(w[23:22]);
        int kind = 6, size = 0;
        logic sg = 0, d64 = 0;
        logic [63:0] base, off, ext;
        e.v = 1;
        if (w[29:27] == 3'b111 && w[25:24] == 0 && w[21] && w[11:10] == 2'b10 && w[14]) begin
            if (w[26]) begin
                size = (opc / 2) * 4 + sz;
                if (size <= 4) kind = (opc % 2 == 1) ? 4 : 3;
            end else if (sz == 3 && opc == 2) begin
                kind = 5; size = 3;
            end else if (!(opc == 3 && sz >= 2)) begin
                size = sz;
                if (opc == 0) begin kind = 0; d64 = (sz == 3); end
                else if (opc == 1) begin kind = 1; d64 = (sz == 3); end
                else begin kind = 2; sg = 1; d64 = (opc == 2); end
            end
        end
        e.k = kind[2:0];
        if (kind == 6) begin e.un = 1; return e; end
        e.sz = size[2:0]; e.sg = sg; e.d64 = d64;
        e.wr = (kind == 1 || kind == 2 || kind == 4);
        e.rt = w[4:0]; e.rn = w[9:5]; e.rm = w[20:16];
        base = (w[9:5] == 31) ? sp : b;
        off = (w[20:16] == 31) ? 64'd0 : o;
        if (w[15:13] == 3'b010) ext = {32'd0, off[31:0]};
        else if (w[15:13] == 3'b110) ext = {{32{off[31]}}, off[31:0]};
        else ext = off;
        if (w[12]) ext = ext << size;
        e.a = base + ext;
        e.flt = (w[9:5] == 31) && (sp[3:0] != 0);
        return e;
    endfunction

    function automatic exp_t actual();
        return '{out_valid, out_unalloc, out_kind, out_size, out_signed, out_dst64,
                 out_reg_write, out_rt, out_rn, out_rm, out_sp_fault, out_addr};
    endfunction

    // Compare the output of the instruction applied at the previous negedge.
    task automatic compare();
        exp_t e, a;
        string t;
        if (pend.size() == 0) return;
        e = pend.pop_front();
        t = ptag.pop_front();
        a = actual();
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", t, a, e);
        end
    endtask

    task automatic step(input logic vld, input logic [31:0] w, input logic [63:0] b,
                        input logic [63:0] sp, input logic [63:0] o, input string tag);
        @(negedge clk);
        compare();
        in_valid = vld; in_insn = w; in_base = b; in_sp = sp; in_offset = o;
        pend.push_back(vld ? model(w, b, sp, o) : idle_exp());
        ptag.push_back(tag);
    endtask

    initial begin
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    localparam logic [63:0] B = 64'h0000_1000_0000_0000;
    localparam logic [63:0] NEG = 64'h1234_5678_8000_0010;

    initial begin
        repeat (3) @(negedge clk);
        checks++;  // R11 reset state
        if (actual() !== idle_exp()) begin
            errors++;
            $display("FAIL R11 actual=%h expected=%h", actual(), idle_exp());
        end
        rst_n = 1'b1;
        // R2 integer classes, all sizes, and R5 widths
        for (int sz = 0; sz < 4; sz++)
            for (int opc = 0; opc < 4; opc++)
                step(1, mk(sz, 0, opc, 3, 3'b011, 0, 4, 7), B, 64'h80, 64'h40, "R2_R3_R5");
        // R4 vector sizes including the 4/5 boundary
        for (int opc = 0; opc < 4; opc++)
            for (int sz = 0; sz < 4; sz++)
                step(1, mk(sz, 1, opc, 2, 3'b111, 1, 6, 1), B, 64'h80, 64'h3, "R4_R7");
        // R1 fixed-field violations and opt[1]=0
        step(1, mk(2, 0, 1, 3, 3'b001, 0, 4, 7), B, 64'h81, 64'h40, "R1_opt");
        step(1, mk(2, 0, 1, 3, 3'b100, 0, 31, 7), B, 64'h81, 64'h40, "R1_opt");
        step(1, mk(3, 0, 2, 3, 3'b000, 0, 4, 7), B, 64'h80, 64'h40, "R1_prefetch_opt");
        step(1, mk(2, 0, 1, 3, 3'b011, 0, 4, 7) ^ 32'h0000_0800, B, 64'h80, 64'h40, "R1_bit11");
        step(1, mk(2, 0, 1, 3, 3'b011, 0, 4, 7) ^ 32'h0020_0000, B, 64'h80, 64'h40, "R1_bit21");
        step(1, mk(2, 0, 1, 3, 3'b011, 0, 4, 7) ^ 32'h0100_0000, B, 64'h80, 64'h40, "R1_bit24");
        step(1, mk(2, 0, 1, 3, 3'b011, 0, 4, 7) ^ 32'h1000_0000, B, 64'h80, 64'h40, "R1_bit28");
        // R6 extend modes with bit 31 set, R7 scaling on and off
        for (int s = 0; s < 2; s++) begin
            step(1, mk(1, 0, 1, 9, 3'b010, s, 4, 7), B, 64'h0, NEG, "R6_uxtw_R7");
            step(1, mk(1, 0, 1, 9, 3'b110, s, 4, 7), B, 64'h0, NEG, "R6_sxtw_R7");
            step(1, mk(3, 0, 0, 9, 3'b011, s, 4, 7), B, 64'h0, NEG, "R6_full_R7");
            step(1, mk(0, 0, 3, 9, 3'b111, s, 4, 7), B, 64'h0, NEG, "R6_sfull_R7");
        end
        step(1, mk(3, 0, 1, 9, 3'b110, 1, 4, 7), 64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 64'h10, "R7_wrap");
        // R8 and R9: stack pointer base and zero offset register
        step(1, mk(3, 0, 1, 31, 3'b011, 1, 31, 2), B, 64'h7000, 64'h55, "R8_sp_zr");
        step(1, mk(3, 0, 1, 5, 3'b011, 1, 31, 2), B, 64'h7008, 64'h55, "R8_R9_fault");
        step(1, mk(0, 0, 0, 5, 3'b011, 0, 31, 2), B, 64'h700F, 64'h1, "R9_fault");
        step(1, mk(0, 0, 0, 5, 3'b011, 0, 30, 2), B, 64'h700F, 64'h1, "R9_nosp");
        step(1, mk(2, 1, 3, 5, 3'b011, 0, 31, 2), B, 64'h7004, 64'h1, "R9_unalloc_nofault");
        step(1, mk(3, 0, 2, 5, 3'b011, 0, 31, 2), B, 64'h7001, 64'h1, "R3_R9_prefetch");
        // R10 idle cycles and back-to-back traffic
        step(0, mk(0, 0, 1, 1, 3'b011, 0, 1, 1), B, 64'h0, 64'h1, "R10_idle");
        step(1, mk(0, 0, 1, 1, 3'b011, 0, 1, 1), B, 64'h0, 64'h1, "R10_resume");
        step(0, 32'hFFFF_FFFF, B, 64'h0, 64'h1, "R10_idle");
        step(0, 32'h0, 0, 0, 0, "R10_drain");
        @(negedge clk);
        compare();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule